// File: doc/BRIEF.md
# Hardware Message Enqueue Engine

A sending processor posts a fixed 4-byte message with a single register write. The write carries the destination number. The engine selects that destination's queue and allocates the next free node. It then appends the node to a singly linked list in the receiving processor's memory through a write-only memory master that uses a request/grant handshake. The sender needs no other handshake.

Each node takes 8 bytes: the 32-bit payload word at the node address and the next-pointer word at node address + 4. A next pointer of zero ends the list. For every destination a configuration port gives three addresses: the head-pointer word, the tail-pointer word and the base of the node pool.

The node is published by one write. For a non-empty queue that write goes to the link field of the old tail. For an empty queue it goes to the head word. Until that write lands, the receiver cannot reach the new node. A message for the sender's own processor follows exactly the same path, so software needs no local interlock. The engine keeps no list state except a per-destination count of allocated nodes. Software dequeue is outside the engine's scope, so nodes are never returned.

Top module: `msgq_enqueue`

## Requirements
- R1: After reset `busy`, `overflow`, `mem_req` and every bit of `full` are 0.
- R2: An accepted send produces exactly four memory writes in this order: payload at the node address, zero at node + 4, the link write, then the node address written to the destination's tail-pointer word.
- R3: If the destination queue holds no node, the link write stores the node address into the destination's head-pointer word.
- R4: If the destination queue is not empty, the link write stores the node address at old-tail node + 4, which is the new node address minus 4.
- R5: The k-th node allocated for a destination (k counted from 0) is at node base + 8*k.
- R6: `busy` is 1 from the cycle after the accepted send write until the cycle after the fourth write is granted. `mem_req` is 1 exactly while `busy` is 1.
- R7: A send write while `busy` is 1 is dropped and sets `overflow`. `overflow` stays 1 until reset.
- R8: After NODES messages to a destination, that destination's `full` bit is 1. A send to it then produces no memory write and leaves `busy` at 0. Other destinations keep working.
- R9: While `mem_req` is 1 and `mem_gnt` is 0, the request, address and data are held unchanged.
- R10: Each destination, including number 0 (the sender's own processor), has its own node count and list, and every destination uses the same path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send_wr | input | 1 | Send register write strobe |
| send_dest | input | DEST_W | Destination number carried with the write |
| send_data | input | 32 | Message payload |
| busy | output | 1 | Append in progress |
| overflow | output | 1 | Sticky: a send was dropped because the engine was busy |
| full | output | NDEST | Per-destination node pool exhausted |
| cfg_head_addr | input | NDEST*AW | Per-destination address of the head-pointer word |
| cfg_tail_addr | input | NDEST*AW | Per-destination address of the tail-pointer word |
| cfg_node_base | input | NDEST*AW | Per-destination node pool base |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; a write completes when req and gnt are both 1 |

## Verification
A wrong allocation count shows up at the ports on the very next send to that destination. The node address in the payload write is wrong, and so is the choice between a head write and a tail-link write. A `full` bit that changes too early or too late also gives it away. An FSM that skips or reorders a step gives a wrong write sequence, or a `busy` value that disagrees with the grant count, within the cycle it happens. The bench stalls the grant on an irregular pattern so that hold faults become visible, and it compares every output against a reference model on every clock.

// File: rtl/msgq_pkg.sv
// Shared types for the message enqueue engine.
package msgq_pkg;
    // Append sequence steps; order equals the memory write order.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PAY  = 3'd1,
        ST_NULL = 3'd2,
        ST_LINK = 3'd3,
        ST_TAIL = 3'd4
    } step_t;
endpackage

// File: rtl/msgq_alloc_table.sv
// Per-destination node allocation counters.
// Assumes commit pulses once per completed append and never for a full destination.
module msgq_alloc_table #(
    parameter int NDEST = 4,
    parameter int NODES = 8,
    localparam int CW = $clog2(NODES + 1),
    localparam int DW = (NDEST > 1) ? $clog2(NDEST) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DW-1:0]     commit_dest,
    output logic [NDEST*CW-1:0] cnt_flat,
    output logic [NDEST-1:0]  full
);
    for (genvar d = 0; d < NDEST; d++) begin : g_dest
        logic [CW-1:0] cnt;

        // Count nodes handed out for this destination.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (commit && commit_dest == DW'(d))
                cnt <= cnt + 1'b1;
        end

        assign cnt_flat[d*CW +: CW] = cnt;
        assign full[d] = (cnt == CW'(NODES));

        // R8
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && commit_dest == DW'(d)) |-> (cnt < CW'(NODES)));
    end
endmodule

// File: rtl/msgq_seq.sv
// Append sequencer: accepts a send, then issues payload, null link,
// publish and tail-word writes over a request/grant port.
// Assumes the allocation count of the captured destination is stable while busy.
module msgq_seq
    import msgq_pkg::*;
#(
    parameter int NDEST = 4,
    parameter int NODES = 8,
    parameter int AW    = 16,
    localparam int CW = $clog2(NODES + 1),
    localparam int DW = (NDEST > 1) ? $clog2(NDEST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               send_wr,
    input  logic [DW-1:0]      send_dest,
    input  logic [31:0]        send_data,
    input  logic [NDEST-1:0]   full,
    input  logic [NDEST*CW-1:0] cnt_flat,
    input  logic [NDEST*AW-1:0] cfg_head_addr,
    input  logic [NDEST*AW-1:0] cfg_tail_addr,
    input  logic [NDEST*AW-1:0] cfg_node_base,
    output logic               busy,
    output logic               overflow,
    output logic               commit,
    output logic [DW-1:0]      dest_q,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_gnt
);
    step_t       st;
    logic [31:0] data_q;
    logic [CW-1:0] cnt_sel;
    logic [AW-1:0] node_addr;
    logic        accept;

    assign accept  = (st == ST_IDLE) && send_wr && !full[send_dest];
    assign busy    = (st != ST_IDLE);
    assign mem_req = busy;
    assign commit  = (st == ST_TAIL) && mem_gnt;
    assign cnt_sel = cnt_flat[dest_q*CW +: CW];
    assign node_addr = cfg_node_base[dest_q*AW +: AW] + (AW'(cnt_sel) << 3);

    // Step through the write sequence, advancing on each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            dest_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            st     <= ST_PAY;
            dest_q <= send_dest;
            data_q <= send_data;
        end else if (busy && mem_gnt) begin
            case (st)
                ST_PAY:  st <= ST_NULL;
                ST_NULL: st <= ST_LINK;
                ST_LINK: st <= ST_TAIL;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Latch the drop of any send that arrives during an append.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (send_wr && busy)
            overflow <= 1'b1;
    end

    // Select address and data for the current step.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_PAY: begin
                mem_addr  = node_addr;
                mem_wdata = data_q;
            end
            ST_NULL: begin
                mem_addr  = node_addr + AW'(4);
                mem_wdata = '0;
            end
            ST_LINK: begin
                mem_addr  = (cnt_sel == '0) ? cfg_head_addr[dest_q*AW +: AW]
                                            : node_addr - AW'(4);
                mem_wdata = 32'(node_addr);
            end
            ST_TAIL: begin
                mem_addr  = cfg_tail_addr[dest_q*AW +: AW];
                mem_wdata = 32'(node_addr);
            end
            default: ;
        endcase
    end

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
    // R7
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(send_wr));
    // R8
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && send_wr && full[send_dest]) |=> !busy);
endmodule

// File: rtl/msgq_enqueue.sv
// Top of the message enqueue engine: one send register feeding an
// atomic linked-list append in the receiver's memory, per destination.
// Assumes node pools do not start at address 0 and do not overlap.
module msgq_enqueue #(
    parameter int NDEST = 4,
    parameter int NODES = 8,
    parameter int AW    = 16,
    localparam int CW = $clog2(NODES + 1),
    localparam int DEST_W = (NDEST > 1) ? $clog2(NDEST) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                send_wr,
    input  logic [DEST_W-1:0]   send_dest,
    input  logic [31:0]         send_data,
    output logic                busy,
    output logic                overflow,
    output logic [NDEST-1:0]    full,
    input  logic [NDEST*AW-1:0] cfg_head_addr,
    input  logic [NDEST*AW-1:0] cfg_tail_addr,
    input  logic [NDEST*AW-1:0] cfg_node_base,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic                mem_gnt
);
    logic              commit;
    logic [DEST_W-1:0] dest_q;
    logic [NDEST*CW-1:0] cnt_flat;

    msgq_alloc_table #(.NDEST(NDEST), .NODES(NODES)) u_table (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_dest(dest_q),
        .cnt_flat(cnt_flat), .full(full)
    );

    msgq_seq #(.NDEST(NDEST), .NODES(NODES), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .send_wr(send_wr), .send_dest(send_dest),
        .send_data(send_data), .full(full), .cnt_flat(cnt_flat),
        .cfg_head_addr(cfg_head_addr), .cfg_tail_addr(cfg_tail_addr),
        .cfg_node_base(cfg_node_base), .busy(busy), .overflow(overflow),
        .commit(commit), .dest_q(dest_q), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
    );
endmodule

// File: tb/msgq_enqueue_test.sv
module msgq_enqueue_test;
    localparam int NDEST = 4;
    localparam int NODES = 8;
    localparam int AW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_wr = 1'b0;
    logic [1:0] send_dest = '0;
    logic [31:0] send_data = '0;
    logic busy, overflow, mem_req, mem_gnt;
    logic [NDEST-1:0] full;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [NDEST*AW-1:0] cfg_head_addr, cfg_tail_addr, cfg_node_base;

    always #10 clk = ~clk;

    msgq_enqueue #(.NDEST(NDEST), .NODES(NODES), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .send_wr(send_wr), .send_dest(send_dest),
        .send_data(send_data), .busy(busy), .overflow(overflow), .full(full),
        .cfg_head_addr(cfg_head_addr), .cfg_tail_addr(cfg_tail_addr),
        .cfg_node_base(cfg_node_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
    );

    function automatic logic [AW-1:0] head_of(int d); return AW'(16'h0100 + d*8); endfunction
    function automatic logic [AW-1:0] tail_of(int d); return AW'(16'h0104 + d*8); endfunction
    function automatic logic [AW-1:0] base_of(int d); return AW'(16'h1000 + d*16'h0400); endfunction

    initial begin
        for (int d = 0; d < NDEST; d++) begin
            cfg_head_addr[d*AW +: AW] = head_of(d);
            cfg_tail_addr[d*AW +: AW] = tail_of(d);
            cfg_node_base[d*AW +: AW] = base_of(d);
        end
    end

    // Reference model state
    int checks = 0, fails = 0, cyc = 0;
    bit m_busy = 0, m_ovf = 0;
    int m_left = 0, m_dest = 0;
    int m_cnt [NDEST];
    logic [AW-1:0] q_addr[$];
    logic [31:0]   q_data[$];
    string         q_tag[$];

    // Grant pattern with irregular stalls
    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_gnt <= ((cyc % 5) != 1) && ((cyc % 7) != 3);
    end

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Model update at each edge from inputs and model state only
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_ovf = 0; m_left = 0;
            for (int d = 0; d < NDEST; d++) m_cnt[d] = 0;
            q_addr.delete(); q_data.delete(); q_tag.delete();
        end else begin
            bit was_busy;
            was_busy = m_busy;
            if (was_busy && mem_gnt) begin
                void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_cnt[m_dest]++;
                end
            end
            if (send_wr) begin
                if (was_busy) m_ovf = 1;
                else if (m_cnt[send_dest] < NODES) begin
                    logic [AW-1:0] node;
                    m_dest = send_dest;
                    node = base_of(m_dest) + AW'(8 * m_cnt[m_dest]);
                    q_addr.push_back(node);        q_data.push_back(send_data); q_tag.push_back("R2/R5 payload");
                    q_addr.push_back(node + 4);    q_data.push_back(32'h0);     q_tag.push_back("R2 null");
                    if (m_cnt[m_dest] == 0) begin
                        q_addr.push_back(head_of(m_dest)); q_tag.push_back("R3 head");
                    end else begin
                        q_addr.push_back(base_of(m_dest) + AW'(8 * (m_cnt[m_dest] - 1) + 4));
                        q_tag.push_back("R4 link");
                    end
                    q_data.push_back(32'(node));
                    q_addr.push_back(tail_of(m_dest)); q_data.push_back(32'(node)); q_tag.push_back("R2 tail");
                    m_busy = 1; m_left = 4;
                end
            end
        end
    end

    // Compare every cycle away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NDEST-1:0] mf;
            for (int d = 0; d < NDEST; d++) mf[d] = (m_cnt[d] == NODES);
            chk(busy === m_busy, "R6", "busy", busy, m_busy);
            chk(mem_req === m_busy, "R6", "mem_req", mem_req, m_busy);
            chk(overflow === m_ovf, "R7", "overflow", overflow, m_ovf);
            chk(full === mf, "R8/R10", "full", full, mf);
            if (m_busy && q_addr.size() > 0) begin
                chk(mem_addr === q_addr[0], q_tag[0], "addr", mem_addr, q_addr[0]);
                chk(mem_wdata === q_data[0], q_tag[0], "data", mem_wdata, q_data[0]);
            end
        end
    end

    task automatic send(int d, logic [31:0] v);
        @(negedge clk);
        send_wr = 1; send_dest = 2'(d); send_data = v;
        @(negedge clk);
        send_wr = 0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (m_busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(busy === 0 && mem_req === 0, "R1", "busy/req", {busy, mem_req}, 0);
        chk(overflow === 0, "R1", "overflow", overflow, 0);
        chk(full === '0, "R1", "full", full, 0);
        rst_n = 1;
        // R10 destination 0 is the sender's own processor
        send(0, 32'hA0A0_0001); drain();
        send(0, 32'hA0A0_0002); drain();
        send(2, 32'hC2C2_0001); drain();
        send(0, 32'hA0A0_0003); drain();
        // R8 fill destination 1, then one refused
        for (int k = 0; k < NODES; k++) begin
            send(1, 32'hB1B1_0000 + k); drain();
        end
        send(1, 32'hDEAD_BEEF);
        repeat (3) @(negedge clk);
        chk(busy === 0, "R8", "refused busy", busy, 0);
        chk(overflow === 0, "R8", "no overflow on refuse", overflow, 0);
        send(3, 32'hD3D3_0001); drain();
        // R7 back-to-back writes: second dropped
        @(negedge clk);
        send_wr = 1; send_dest = 2; send_data = 32'hC2C2_0002;
        @(negedge clk);
        send_data = 32'hBAD0_0001;
        @(negedge clk);
        send_wr = 0;
        drain();
        chk(overflow === 1, "R7", "overflow set", overflow, 1);
        send(2, 32'hC2C2_0003); drain();
        repeat (3) @(negedge clk);
        chk(overflow === 1, "R7", "overflow sticky", overflow, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule